// File: doc/BRIEF.md
# Cache Valid-Bit Store with Deferred Write Stage

This block holds the valid flags for a direct-mapped data cache. There is one flag for every 32-bit data word, so the default 16 KB cache needs 4096 flags, selected by a 12-bit word index. Two load/store pipes read their flags in the same cycle as the access. Each read port returns its flag combinationally from the address presented in that cycle.

A flag can only be updated once the hit check has finished, and that check does not fit in the access cycle. The update is therefore issued one cycle later, from the pipeline's write stage, on one of two dedicated write ports. A write presented in cycle t is committed at the clock edge that ends cycle t. Any read in cycle t that names the same entry is forwarded the value being written, so neither pipe ever sees a stale flag. A global invalidate empties the whole store in a single edge.

Top module: `vb_valid_array`

## Requirements
- R1: At the first clock edge with `rst_n` low every flag is cleared. After that edge, a read with no pending write to the same entry returns 0. While `rst_n` is low both read outputs are 0.
- R2: A read port returns the stored flag of the entry at its address in the same cycle, with no register between the address and the output.
- R3: A write with its enable high in cycle t stores its data bit into the addressed entry at the edge that ends cycle t. A read of that entry in cycle t+1 with no write pending returns the written bit.
- R4: Both write ports may update two different entries in the same cycle, and both updates take effect.
- R5: When both write ports target the same entry in one cycle, the stored value is the data of write port 1.
- R6: A read whose address equals the address of an enabled write in the same cycle returns that write's data, not the stored flag.
- R7: When a read address matches both enabled write addresses in the same cycle, the read returns write port 1's data.
- R8: When `inval_all` is high, every flag is 0 after the next edge, and writes in that cycle are discarded. Reads in that cycle return 0.
- R9: A write port whose enable is low changes no entry and is never forwarded, whatever its address and data.
- R10: Writing a 0 clears a flag that was set.
- R11: Entries are independent. A write changes only the entry at its linear word index, including neighbours that share its storage row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_addr | input | 12 | Word index read by pipe 0 |
| rd1_addr | input | 12 | Word index read by pipe 1 |
| wr0_en | input | 1 | Write-stage update from pipe 0 |
| wr0_addr | input | 12 | Word index updated by write port 0 |
| wr0_data | input | 1 | New flag value for write port 0 |
| wr1_en | input | 1 | Write-stage update from pipe 1 |
| wr1_addr | input | 12 | Word index updated by write port 1 |
| wr1_data | input | 1 | New flag value for write port 1 |
| inval_all | input | 1 | Clear every flag at the next edge |
| rd0_valid | output | 1 | Flag seen by pipe 0 this cycle |
| rd1_valid | output | 1 | Flag seen by pipe 1 this cycle |

## Verification
The hardest case to reach is a cycle in which both write ports name one entry with opposite data, both read ports look at that entry and at a neighbour in the same storage row, and an invalidate may land in the same cycle. Uniform random addresses over 4096 entries almost never collide like this. The stimulus therefore uses directed cycles for each such case, then a long random run whose addresses come from a small pool that spans two storage rows, with occasional invalidates. A full read scan after reset and after an invalidate confirms that no entry survives.

// File: rtl/vb_pkg.sv
// Package vb_pkg
// Shared defaults and the forwarding-source encoding of the valid-bit store.
// Assumes nothing beyond a 1800-2017 compiler.
package vb_pkg;
    localparam int VB_ADDR_W_DEF = 12;   // 4096 word flags
    localparam int VB_COL_W_DEF  = 6;    // 64 flags per storage row
    localparam int VB_NUM_RD     = 2;    // read ports (one per pipe)

    // Where a read port takes its result from in the current cycle.
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_WR0   = 2'd1,
        SRC_WR1   = 2'd2,
        SRC_FLUSH = 2'd3
    } vb_src_e;
endpackage

// File: rtl/vb_row.sv
// Module vb_row
// One storage row of valid flags with two write ports.
// Port 1 is applied after port 0, so port 1 wins on the same column.
// A flush (reset or invalidate) clears the row and beats any write.
// Assumes the write enables are already qualified by the row decode.
module vb_row #(
    parameter int COL_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inval,
    input  logic                     we0,
    input  logic [COL_W-1:0]         col0,
    input  logic                     d0,
    input  logic                     we1,
    input  logic [COL_W-1:0]         col1,
    input  logic                     d1,
    output logic [(1<<COL_W)-1:0]    bits_q
);
    localparam int ROW_BITS = 1 << COL_W;

    logic [ROW_BITS-1:0] bits_d;

    // Merge both column updates into the next row value, port 1 last.
    always_comb begin
        bits_d = bits_q;
        if (we0) bits_d[col0] = d0;
        if (we1) bits_d[col1] = d1;
    end

    // Row register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || inval) bits_q <= '0;
        else                 bits_q <= bits_d;
    end

    assert_wr1_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we1 && !inval) |=> (bits_q[$past(col1)] == $past(d1)));

    assert_wr0_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && !inval && !(we1 && col1 == col0)) |=> (bits_q[$past(col0)] == $past(d0)));

    assert_inval_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (bits_q == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we0 && !we1 && !inval) |=> $stable(bits_q));
endmodule

// File: rtl/vb_storage.sv
// Module vb_storage
// Flag array organised as rows of 2**COL_W flags. It decodes the two write
// ports onto the rows and gives a combinational read for each read port.
// Assumes ADDR_W > COL_W. Address = {row, column}, linear word index.
module vb_storage
    import vb_pkg::*;
#(
    parameter int ADDR_W = VB_ADDR_W_DEF,
    parameter int COL_W  = VB_COL_W_DEF
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             inval,
    input  logic                             wr0_en,
    input  logic [ADDR_W-1:0]                wr0_addr,
    input  logic                             wr0_data,
    input  logic                             wr1_en,
    input  logic [ADDR_W-1:0]                wr1_addr,
    input  logic                             wr1_data,
    input  logic [VB_NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    output logic [VB_NUM_RD-1:0]             rd_bit
);
    localparam int ROW_W    = ADDR_W - COL_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int ROW_BITS = 1 << COL_W;

    logic [ROWS-1:0][ROW_BITS-1:0] rows_q;
    logic [ROW_W-1:0] wrow0, wrow1;
    logic [COL_W-1:0] wcol0, wcol1;
    logic [ROWS-1:0]  we0_vec, we1_vec;

    // Split write addresses into row and column.
    always_comb begin
        wrow0 = wr0_addr[ADDR_W-1:COL_W];
        wrow1 = wr1_addr[ADDR_W-1:COL_W];
        wcol0 = wr0_addr[COL_W-1:0];
        wcol1 = wr1_addr[COL_W-1:0];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Row select for both write ports.
        always_comb begin
            we0_vec[r] = wr0_en && (wrow0 == ROW_W'(r));
            we1_vec[r] = wr1_en && (wrow1 == ROW_W'(r));
        end

        vb_row #(.COL_W(COL_W)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .inval  (inval),
            .we0    (we0_vec[r]),
            .col0   (wcol0),
            .d0     (wr0_data),
            .we1    (we1_vec[r]),
            .col1   (wcol1),
            .d1     (wr1_data),
            .bits_q (rows_q[r])
        );
    end

    for (genvar p = 0; p < VB_NUM_RD; p++) begin : g_rd
        // Combinational row and column pick for one read port.
        always_comb begin
            rd_bit[p] = rows_q[rd_addr[p][ADDR_W-1:COL_W]][rd_addr[p][COL_W-1:0]];
        end
    end
endmodule

// File: rtl/vb_bypass.sv
// Module vb_bypass
// Forwarding selector for one read port. A flush forces 0. Otherwise a
// matching enabled write supplies the result, port 1 ahead of port 0.
// Otherwise the stored flag is returned. Purely combinational.
module vb_bypass
    import vb_pkg::*;
#(
    parameter int ADDR_W = VB_ADDR_W_DEF
) (
    input  logic              flush,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              arr_bit,
    input  logic              wr0_en,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic              wr0_data,
    input  logic              wr1_en,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic              wr1_data,
    output logic              rd_valid
);
    vb_src_e src;

    // Choose the source in priority order.
    always_comb begin
        if (flush)                                 src = SRC_FLUSH;
        else if (wr1_en && (wr1_addr == rd_addr))  src = SRC_WR1;
        else if (wr0_en && (wr0_addr == rd_addr))  src = SRC_WR0;
        else                                       src = SRC_ARRAY;
    end

    // Drive the result from the chosen source.
    always_comb begin
        unique case (src)
            SRC_FLUSH: rd_valid = 1'b0;
            SRC_WR1:   rd_valid = wr1_data;
            SRC_WR0:   rd_valid = wr0_data;
            default:   rd_valid = arr_bit;
        endcase
    end
endmodule

// File: rtl/vb_valid_array.sv
// Module vb_valid_array
// Valid-flag store for a direct-mapped data cache. It has two same-cycle
// read ports and two write-stage ports committed at the next edge, with
// forwarding from pending writes to reads and a global one-edge invalidate.
// Assumes the write stage presents each update exactly one cycle after its
// access. Reads while rst_n is low return 0.
module vb_valid_array
    import vb_pkg::*;
#(
    parameter int ADDR_W = VB_ADDR_W_DEF,
    parameter int COL_W  = VB_COL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd0_addr,
    input  logic [ADDR_W-1:0] rd1_addr,
    input  logic              wr0_en,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic              wr0_data,
    input  logic              wr1_en,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic              wr1_data,
    input  logic              inval_all,
    output logic              rd0_valid,
    output logic              rd1_valid
);
    logic [VB_NUM_RD-1:0][ADDR_W-1:0] rd_addr;
    logic [VB_NUM_RD-1:0]             arr_bit;
    logic [VB_NUM_RD-1:0]             rd_out;
    logic                             flush;

    // Gather the read ports and form the flush condition.
    always_comb begin
        rd_addr[0] = rd0_addr;
        rd_addr[1] = rd1_addr;
        flush      = inval_all || !rst_n;
        rd0_valid  = rd_out[0];
        rd1_valid  = rd_out[1];
    end

    vb_storage #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (inval_all),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .rd_addr  (rd_addr),
        .rd_bit   (arr_bit)
    );

    for (genvar p = 0; p < VB_NUM_RD; p++) begin : g_fwd
        vb_bypass #(.ADDR_W(ADDR_W)) u_fwd (
            .flush    (flush),
            .rd_addr  (rd_addr[p]),
            .arr_bit  (arr_bit[p]),
            .wr0_en   (wr0_en),
            .wr0_addr (wr0_addr),
            .wr0_data (wr0_data),
            .wr1_en   (wr1_en),
            .wr1_addr (wr1_addr),
            .wr1_data (wr1_data),
            .rd_valid (rd_out[p])
        );
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        (!rst_n) |=> ((!wr0_en && !wr1_en) -> (!rd0_valid && !rd1_valid)));

    assert_fwd_wr1_p0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_en && rd0_addr == wr1_addr && !inval_all) |-> (rd0_valid == wr1_data));

    assert_fwd_wr1_p1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1_en && rd1_addr == wr1_addr && !inval_all) |-> (rd1_valid == wr1_data));

    assert_fwd_wr0_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && rd0_addr == wr0_addr && !(wr1_en && rd0_addr == wr1_addr) && !inval_all)
        |-> (rd0_valid == wr0_data));

    assert_inval_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> (!rd0_valid && !rd1_valid));

    assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && !inval_all && !(wr1_en && wr1_addr == wr0_addr))
        |=> ((rd0_addr == $past(wr0_addr) && !wr0_en && !wr1_en && !inval_all)
             -> (rd0_valid == $past(wr0_data))));
endmodule

// File: tb/tb_vb_valid_array.sv
// Bench for vb_valid_array. A behavioural flag model (one bit per word
// index) predicts both read outputs every cycle and is updated at each edge.
module tb_vb_valid_array;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WATCHDOG_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] rd0_addr = '0, rd1_addr = '0, wr0_addr = '0, wr1_addr = '0;
    logic wr0_en = 1'b0, wr0_data = 1'b0, wr1_en = 1'b0, wr1_data = 1'b0, inval_all = 1'b0;
    logic rd0_valid, rd1_valid;

    bit model [DEPTH];
    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vb_valid_array dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .inval_all(inval_all),
        .rd0_valid(rd0_valid), .rd1_valid(rd1_valid)
    );

    // Expected flag seen by a read of address a under the current inputs.
    function automatic bit predict(input logic [ADDR_W-1:0] a);
        if (inval_all) return 1'b0;
        if (wr1_en && wr1_addr == a) return wr1_data;
        if (wr0_en && wr0_addr == a) return wr0_data;
        return model[a];
    endfunction

    task automatic compare(input int port, input logic act, input bit exp,
                           input logic [ADDR_W-1:0] a, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s port%0d addr=%0d actual=%b expected=%b", tag, port, a, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, check mid-low phase, commit the model at the rising edge.
    task automatic cyc(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1,
                       input logic e0, input logic [ADDR_W-1:0] wa0, input logic d0,
                       input logic e1, input logic [ADDR_W-1:0] wa1, input logic d1,
                       input logic inv, input string tag);
        @(negedge clk);
        rd0_addr = a0; rd1_addr = a1;
        wr0_en = e0; wr0_addr = wa0; wr0_data = d0;
        wr1_en = e1; wr1_addr = wa1; wr1_data = d1;
        inval_all = inv;
        #(CLK_P/4);
        compare(0, rd0_valid, predict(a0), a0, tag);
        compare(1, rd1_valid, predict(a1), a1, tag);
        @(posedge clk);
        if (inv) begin
            for (int i = 0; i < DEPTH; i++) model[i] = 1'b0;
        end else begin
            if (e0) model[wa0] = d0;
            if (e1) model[wa1] = d1;
        end
    endtask

    task automatic rd2(input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1, input string tag);
        cyc(a0, a1, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // Address from a small pool over two rows, now and then anywhere.
    function automatic logic [ADDR_W-1:0] pick;
        if ($urandom % 8 == 0) return ADDR_W'($urandom % DEPTH);
        return ADDR_W'($urandom % 8) + (($urandom % 2 == 1) ? ADDR_W'(64) : ADDR_W'(0));
    endfunction

    initial begin
        // Reset for three cycles, reads forced to 0 (R1).
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        compare(0, rd0_valid, 1'b0, rd0_addr, "R1 in reset");
        compare(1, rd1_valid, 1'b0, rd1_addr, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry reads 0 after reset.
        for (int i = 0; i < DEPTH; i += 2) rd2(ADDR_W'(i), ADDR_W'(i + 1), "R1");

        // R6 forwarding then R3 / R2 commit and same-cycle read.
        cyc(12'd5, 12'd6, 1'b1, 12'd5, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6");
        rd2(12'd5, 12'd6, "R3 R2");

        // R4 two ports, different entries, R11 neighbours untouched.
        cyc(12'd99, 12'd102, 1'b1, 12'd100, 1'b1, 1'b1, 12'd101, 1'b1, 1'b0, "R4 R11");
        rd2(12'd100, 12'd101, "R4");
        rd2(12'd99, 12'd102, "R11");

        // R5 / R7 same address on both write ports, both polarities.
        cyc(12'd200, 12'd200, 1'b1, 12'd200, 1'b0, 1'b1, 12'd200, 1'b1, 1'b0, "R7");
        rd2(12'd200, 12'd201, "R5");
        cyc(12'd201, 12'd201, 1'b1, 12'd201, 1'b1, 1'b1, 12'd201, 1'b0, 1'b0, "R7");
        rd2(12'd201, 12'd200, "R5");

        // R9 disabled ports are neither stored nor forwarded.
        cyc(12'd300, 12'd301, 1'b0, 12'd300, 1'b1, 1'b0, 12'd301, 1'b1, 1'b0, "R9");
        rd2(12'd300, 12'd301, "R9");

        // R10 clearing a set flag.
        cyc(12'd5, 12'd100, 1'b1, 12'd5, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10");
        rd2(12'd5, 12'd100, "R10");

        // R8 invalidate beats writes, fill first, then scan everything.
        for (int i = 0; i < 64; i++)
            cyc(ADDR_W'(i * 37), ADDR_W'(i * 53), 1'b1, ADDR_W'(i * 37), 1'b1,
                1'b1, ADDR_W'(i * 53), 1'b1, 1'b0, "R4 R6");
        cyc(12'd400, 12'd100, 1'b1, 12'd400, 1'b1, 1'b1, 12'd100, 1'b1, 1'b1, "R8");
        for (int i = 0; i < DEPTH; i += 2) rd2(ADDR_W'(i), ADDR_W'(i + 1), "R8");

        // Random mix with colliding addresses (R2 R3 R5 R6 R7 R8 R11).
        for (int n = 0; n < 4000; n++)
            cyc(pick(), pick(), 1'($urandom), pick(), 1'($urandom),
                1'($urandom), pick(), 1'($urandom), ($urandom % 97 == 0), "R2 R3 R5 R6 R7 R8 R11");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule